// File: doc/BRIEF.md
# Tapped Binary Frequency Divider

This block is a fourteen-stage binary counter used as a frequency divider. Its only clock is the input being divided. The count goes up by one on every falling edge of that input. A rising edge changes nothing. Ten of the fourteen stage outputs are brought out as tap bits, and each tap is a square wave at the input rate divided by a power of two. Stages 1, 2, 10 and 14 are kept inside the block.

An active-high reset clears the count at once, with no clock edge needed, and it overrides the clock. While the reset is held, the count stays at zero. Counting starts again from zero on the first falling edge after the reset is released. The count runs freely: after all ones it wraps to zero.

Stages are numbered from 1, and stage 1 is the least significant bit of the count. The stage count, the first and last tapped stages and the one hidden stage inside that range are all parameters.

Top module: `tap_divider`

## Requirements
- R1: After reset all ten tap bits read zero.
- R2: Each falling edge of `clk` while `rst` is low raises the 14-bit internal count by exactly one.
- R3: A rising edge of `clk` leaves every tap bit unchanged.
- R4: Raising `rst` clears every tap bit without waiting for any clock edge, whether `clk` is high or low at that moment.
- R5: While `rst` is high, falling edges do not change the count, which stays at zero. The first falling edge after `rst` goes low gives a count of one.
- R6: Stage n is bit n-1 of the count. `taps[6:0]` carry stages 3 to 9, with `taps[0]` = stage 3. `taps[9:7]` carry stages 11 to 13, with `taps[9]` = stage 13.
- R7: From a count of 16383 (all ones), the next falling edge gives zero, and counting continues.
- R8: `taps[0]` toggles once every 4 falling edges, and `taps[9]` toggles once every 4096 falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input signal to be divided; the count advances on its falling edge |
| rst | input | 1 | Asynchronous active-high clear; overrides the clock |
| taps | output | 10 | Tapped stage outputs {s13,s12,s11,s9,s8,s7,s6,s5,s4,s3} |

## Verification
The two lowest stages and stage 10 cannot be seen at the ports, so a fault in them shows up indirectly. A stuck or skipping low stage makes `taps[0]` drift from its four-edge period within a few falling edges. A fault in stage 10 shows up as a wrong `taps[7]` within about a thousand edges. A broken carry into the upper stages may only appear near the top of the count, so the bench runs past one full wrap and compares every tap bit with a reference count after every falling edge. Mid-count reset pulses, one with the clock high and one with it low, show whether the clear really needs no clock edge.

// File: rtl/tap_div_pkg.sv
`timescale 1ns/1ps
package tap_div_pkg;

  // Stage number (1-based) carried by tap j, skipping one hidden stage.
  function automatic int stage_of_tap(input int j, input int first, input int skip);
    int s;
    s = first + j;
    if (s >= skip) s = s + 1;
    return s;
  endfunction

  // Number of taps between first and last stage, minus the hidden one.
  function automatic int tap_count(input int first, input int last, input int skip);
    int n;
    n = last - first + 1;
    if (skip >= first && skip <= last) n = n - 1;
    return n;
  endfunction

endpackage

// File: rtl/div_tstage.sv
`timescale 1ns/1ps
module div_tstage (
  input  logic clk,
  input  logic rst,
  input  logic carry_in,
  output logic q,
  output logic carry_out
);

  // One binary stage: flips when every lower stage is one.
  always_ff @(negedge clk or posedge rst) begin
    if (rst) q <= 1'b0;
    else if (carry_in) q <= ~q;
  end

  assign carry_out = carry_in & q;

endmodule

// File: rtl/div_count_core.sv
`timescale 1ns/1ps
module div_count_core #(
  parameter int STAGES = 14
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STAGES-1:0] count,
  output logic              unused_wrap
);

  logic [STAGES-1:0] carry;
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i < STAGES - 1) begin : g_mid
      div_tstage u_st (
        .clk      (clk),
        .rst      (rst),
        .carry_in (carry[i]),
        .q        (count[i]),
        .carry_out(carry[i+1])
      );
    end else begin : g_last
      div_tstage u_st (
        .clk      (clk),
        .rst      (rst),
        .carry_in (carry[i]),
        .q        (count[i]),
        .carry_out(unused_wrap)
      );
    end
  end

endmodule

// File: rtl/div_tap_select.sv
`timescale 1ns/1ps
module div_tap_select #(
  parameter int STAGES     = 14,
  parameter int FIRST_TAP  = 3,
  parameter int SKIP_STAGE = 10,
  parameter int TAPS       = 10
) (
  input  logic [STAGES-1:0] cnt_i,
  output logic [TAPS-1:0]   taps_o
);

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    localparam int S = tap_div_pkg::stage_of_tap(j, FIRST_TAP, SKIP_STAGE);
    assign taps_o[j] = cnt_i[S-1];
  end

  logic unused_hidden;
  assign unused_hidden = ^cnt_i;

endmodule

// File: rtl/tap_divider.sv
`timescale 1ns/1ps
module tap_divider #(
  parameter int STAGES     = 14,
  parameter int FIRST_TAP  = 3,
  parameter int LAST_TAP   = 13,
  parameter int SKIP_STAGE = 10,
  localparam int TAPS = tap_div_pkg::tap_count(FIRST_TAP, LAST_TAP, SKIP_STAGE)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TAPS-1:0] taps
);

  logic [STAGES-1:0] count_q;
  logic              unused_wrap;

  div_count_core #(.STAGES(STAGES)) u_core (
    .clk        (clk),
    .rst        (rst),
    .count      (count_q),
    .unused_wrap(unused_wrap)
  );

  div_tap_select #(
    .STAGES    (STAGES),
    .FIRST_TAP (FIRST_TAP),
    .SKIP_STAGE(SKIP_STAGE),
    .TAPS      (TAPS)
  ) u_sel (
    .cnt_i (count_q),
    .taps_o(taps)
  );

endmodule

// File: rtl/tap_divider_chk.sv
`timescale 1ns/1ps
module tap_divider_chk #(
  parameter int STAGES = 14,
  parameter int TAPS   = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [TAPS-1:0]   taps,
  input logic [STAGES-1:0] cnt
);

  logic seen;
  always_ff @(negedge clk or posedge rst) begin
    if (rst) seen <= 1'b0;
    else seen <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |-> taps == '0); // R4

  AST_HOLD_IN_RESET: assert property (@(negedge clk) rst |-> cnt == '0); // R5

  AST_STEP_ONE: assert property (@(negedge clk) disable iff (rst)
    (seen && !$past(rst)) |-> cnt == ($past(cnt) + {{(STAGES-1){1'b0}}, 1'b1})); // R2

  AST_WRAP_ZERO: assert property (@(negedge clk) disable iff (rst)
    (seen && !$past(rst) && $past(cnt) == '1) |-> cnt == '0); // R7

  AST_LOW_TAP_RATE: assert property (@(negedge clk) disable iff (rst)
    (seen && !$past(rst)) |->
      ((taps[0] != $past(taps[0])) == ($past(cnt[1:0]) == 2'b11))); // R8

endmodule

bind tap_divider tap_divider_chk #(.STAGES(STAGES), .TAPS(TAPS)) u_chk (
  .clk (clk),
  .rst (rst),
  .taps(taps),
  .cnt (count_q)
);

// File: tb/sim_tap_divider.sv
`timescale 1ns/1ps
module sim_tap_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] taps;

  int checks   = 0;
  int failures = 0;
  int ref_cnt  = 0;
  int tog_lo   = 0;
  int tog_hi   = 0;
  logic [9:0] prev_taps;
  logic [9:0] lo_taps;
  bit done = 0;

  tap_divider u0 (.clk(clk), .rst(rst), .taps(taps));

  always #2 clk = ~clk;

  // Reference: integer count modulo 16384.
  always @(posedge rst) ref_cnt = 0;
  always @(negedge clk) if (!rst) ref_cnt = (ref_cnt + 1) % 16384;

  function automatic logic [9:0] exp_taps(input int c);
    logic [9:0] e;
    for (int j = 0; j < 10; j++) begin
      int s;
      s = (j < 7) ? j + 3 : j + 4;
      e[j] = 1'((c >> (s - 1)) & 1);
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s taps=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock cycle: falling edge, then rising edge. R2/R6 compare and R3 hold check.
  task automatic step();
    logic [9:0] e;
    @(negedge clk); #1;
    lo_taps = taps;
    @(posedge clk); #1;
    check(taps == lo_taps, "R3", taps, lo_taps);
    e = exp_taps(ref_cnt);
    check(taps == e, "R2/R6", taps, e);
    if (taps[0] != prev_taps[0]) tog_lo++;
    if (taps[9] != prev_taps[9]) tog_hi++;
    prev_taps = taps;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 and R5: held in reset across several falling edges.
    repeat (3) begin
      @(negedge clk); #1;
      check(taps == 10'h000, "R5", taps, 10'h000);
    end
    @(posedge clk); #1;
    check(taps == 10'h000, "R1", taps, 10'h000);
    rst = 1'b0;
    prev_taps = taps;
    tog_lo = 0; tog_hi = 0;

    // First four edges after release: count 1..4, so only stage 3 is set at four.
    repeat (4) step();
    check(taps == 10'h001, "R5", taps, 10'h001);

    // Complete one full wrap: 16384 falling edges from release.
    repeat (16380) step();
    check(taps == 10'h000 && ref_cnt == 0, "R7", taps, 10'h000);
    checks++;
    if (tog_lo != 4096) begin failures++; $display("FAIL R8 taps[0] toggles=%0d expected=4096", tog_lo); end
    checks++;
    if (tog_hi != 4) begin failures++; $display("FAIL R8 taps[9] toggles=%0d expected=4", tog_hi); end

    // Continue past the wrap.
    repeat (1000) step();
    check(taps != 10'h000, "R2", taps, exp_taps(ref_cnt));

    // R4: reset raised while clk is high, mid count.
    rst = 1'b1;
    #0.5;
    check(taps == 10'h000, "R4", taps, 10'h000);
    repeat (2) begin
      @(negedge clk); #1;
      check(taps == 10'h000, "R5", taps, 10'h000);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    prev_taps = taps;
    repeat (8) step();
    check(taps == 10'h002, "R5", taps, 10'h002);
    repeat (3000) step();

    // R4: reset raised while clk is low.
    @(negedge clk); #1;
    check(taps != 10'h000, "R4", taps, exp_taps(ref_cnt));
    rst = 1'b1;
    #0.5;
    check(taps == 10'h000, "R4", taps, 10'h000);
    @(negedge clk); #1;
    check(taps == 10'h000, "R5", taps, 10'h000);
    @(posedge clk); #1;
    rst = 1'b0;
    prev_taps = taps;
    repeat (500) step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule